// File: doc/BRIEF.md
# PHY Control-Register Access Bridge

This block lets a host processor reach the 16-bit internal control-register port of a PHY through six 32-bit memory-mapped registers. The host loads an address or a data word into a data-in register, then sets bit 0 of one of four trigger registers. These triggers capture the address, capture the data, launch a write or launch a read. The bridge turns each trigger into one request on the PHY port, holds that request until the PHY acknowledges it, and then clears the trigger bit. Software polls the trigger bit until it reads zero and then moves to the next step.

A PHY write takes three steps: address capture, data capture, then the write trigger. A PHY read takes two steps: address capture, then the read trigger, after which the result sits in the data-out register. The stand-in PHY register array bundled with the bridge behaves like the real port in one respect. The first read after a fresh address capture hands back the previously read word, and only a second read returns the addressed register. Software must therefore read twice and keep the second result.

Top module: `phy_creg_bridge`

## Requirements
- R1: After a synchronous active-low reset, every host register reads 0: data-in, data-out (including the busy flag) and all four trigger registers.
- R2: Data-in at byte offset 0x0C holds all 32 bits the host writes and reads them back unchanged. Only bits 15:0 are sent to the PHY.
- R3: Writing a word with bit 0 set to a trigger register (0x14 address capture, 0x18 data capture, 0x1C read, 0x20 write) while idle starts that operation. Both the trigger's bit 0 and data-out bit 31 then read 1 for exactly ACK_DELAY+1 cycles after the write edge, and read 0 afterwards. At most one PHY request is active at a time, and it is held until the acknowledge.
- R4: A trigger write with bit 0 clear, or any trigger write while an operation is pending, is ignored and leaves the PHY registers unchanged.
- R5: Address capture, then data capture, then the write trigger store the captured data into the PHY register selected by the low log2(MODEL_DEPTH) bits of the captured address.
- R6: Data-out at 0x10 returns the read word in bits 15:0 once the read trigger clears. It keeps that value until the next completed read, whatever else the host does.
- R7: The first read after an address capture returns the word delivered by the previous read (0 after reset). A second read returns the addressed register.
- R8: Each operation uses the data-in value present when its trigger was accepted. Later writes to data-in do not alter it.
- R9: Writes to data-out or to unmapped offsets are ignored, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host write enable, one register per cycle |
| host_addr | input | HOST_AW | Byte offset of the host register |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data for host_addr, combinational |

## Verification
The bench builds the block with its defaults: ACK_DELAY of 3, a 16-entry PHY register array and 16-bit PHY words. An acknowledge delay of 3 leaves enough pending cycles for a second trigger to land while the first is still outstanding, which exercises the ignore path. The array size lets both the stale first read and the fresh second read be seen on distinct stored words. Every cycle, the register at the current host offset is compared against a behavioural model of the register file and the PHY array.

// File: rtl/phy_creg_pkg.sv
// Shared definitions for the PHY control-register bridge.
// Assumes host offsets are byte addresses of 32-bit registers.
package phy_creg_pkg;
    localparam int HOST_DW = 32;
    localparam int NUM_OPS = 4;

    // Host register byte offsets
    localparam int OFS_DIN   = 'h0C;
    localparam int OFS_DOUT  = 'h10;
    localparam int OFS_CADDR = 'h14;
    localparam int OFS_CDATA = 'h18;
    localparam int OFS_READ  = 'h1C;
    localparam int OFS_WRITE = 'h20;

    // PHY port operations; the value is also the request-vector bit index
    typedef enum logic [1:0] {
        OP_CADDR = 2'd0,
        OP_CDATA = 2'd1,
        OP_READ  = 2'd2,
        OP_WRITE = 2'd3
    } op_e;
endpackage

// File: rtl/phy_creg_regs.sv
// Host-side register file: decodes host writes, holds data-in,
// produces a one-cycle launch when an idle trigger bit is set,
// and muxes read data. Assumes one host access per cycle.
module phy_creg_regs
    import phy_creg_pkg::*;
#(
    parameter int HOST_AW = 6,
    parameter int PHY_DW  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    input  logic               busy,
    input  op_e                cur_op,
    input  logic [PHY_DW-1:0]  dout,
    output logic [PHY_DW-1:0]  din_lo,
    output logic               launch,
    output op_e                launch_op
);
    localparam logic [HOST_AW-1:0] A_DIN   = HOST_AW'(OFS_DIN);
    localparam logic [HOST_AW-1:0] A_DOUT  = HOST_AW'(OFS_DOUT);
    localparam logic [HOST_AW-1:0] A_CADDR = HOST_AW'(OFS_CADDR);
    localparam logic [HOST_AW-1:0] A_CDATA = HOST_AW'(OFS_CDATA);
    localparam logic [HOST_AW-1:0] A_READ  = HOST_AW'(OFS_READ);
    localparam logic [HOST_AW-1:0] A_WRITE = HOST_AW'(OFS_WRITE);
    localparam int PAD_W = HOST_DW - 1 - PHY_DW;

    logic [HOST_DW-1:0] din_q;

    // Hold the full host data-in word
    always_ff @(posedge clk) begin
        if (!rst_n)
            din_q <= '0;
        else if (host_wr && host_addr == A_DIN)
            din_q <= host_wdata;
    end

    assign din_lo = din_q[PHY_DW-1:0];

    // Turn an idle trigger write with bit 0 set into a launch
    always_comb begin
        launch    = 1'b0;
        launch_op = OP_CADDR;
        if (host_wr && !busy && host_wdata[0]) begin
            case (host_addr)
                A_CADDR: begin launch = 1'b1; launch_op = OP_CADDR; end
                A_CDATA: begin launch = 1'b1; launch_op = OP_CDATA; end
                A_READ:  begin launch = 1'b1; launch_op = OP_READ;  end
                A_WRITE: begin launch = 1'b1; launch_op = OP_WRITE; end
                default: launch = 1'b0;
            endcase
        end
    end

    // Select the host read word for the addressed register
    always_comb begin
        case (host_addr)
            A_DIN:   host_rdata = din_q;
            A_DOUT:  host_rdata = {busy, {PAD_W{1'b0}}, dout};
            A_CADDR: host_rdata = {{(HOST_DW-1){1'b0}}, busy && cur_op == OP_CADDR};
            A_CDATA: host_rdata = {{(HOST_DW-1){1'b0}}, busy && cur_op == OP_CDATA};
            A_READ:  host_rdata = {{(HOST_DW-1){1'b0}}, busy && cur_op == OP_READ};
            A_WRITE: host_rdata = {{(HOST_DW-1){1'b0}}, busy && cur_op == OP_WRITE};
            default: host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/phy_creg_seq.sv
// Handshake sequencer: snapshots data-in on launch, raises one
// request on the PHY port and holds it until ack, then goes idle.
// Captures PHY read data into data-out on a read acknowledge.
module phy_creg_seq
    import phy_creg_pkg::*;
#(
    parameter int PHY_DW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               launch,
    input  op_e                launch_op,
    input  logic [PHY_DW-1:0]  din_lo,
    output logic               busy,
    output op_e                cur_op,
    output logic [NUM_OPS-1:0] phy_req,
    output logic [PHY_DW-1:0]  phy_bus,
    input  logic               phy_ack,
    input  logic [PHY_DW-1:0]  phy_rdata,
    output logic [PHY_DW-1:0]  dout
);
    // Track the pending operation and latch read results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            cur_op  <= OP_CADDR;
            phy_bus <= '0;
            dout    <= '0;
        end else if (busy) begin
            if (phy_ack) begin
                busy <= 1'b0;
                if (cur_op == OP_READ)
                    dout <= phy_rdata;
            end
        end else if (launch) begin
            busy    <= 1'b1;
            cur_op  <= launch_op;
            phy_bus <= din_lo;
        end
    end

    // One request line per operation, high while that operation is pending
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_req
        assign phy_req[g] = busy && (cur_op == op_e'(g));
    end
endmodule

// File: rtl/phy_creg_model.sv
// Stand-in PHY control-register port: answers each request with an
// ack ACK_DELAY cycles later. The first read after an address capture
// returns the previously read word; later reads return the array entry.
// Assumes ACK_DELAY >= 1 and the requester drops the request after ack.
module phy_creg_model
    import phy_creg_pkg::*;
#(
    parameter int PHY_DW    = 16,
    parameter int DEPTH     = 16,
    parameter int ACK_DELAY = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_OPS-1:0] phy_req,
    input  logic [PHY_DW-1:0]  phy_bus,
    output logic               phy_ack,
    output logic [PHY_DW-1:0]  phy_rdata
);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(ACK_DELAY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_DELAY - 1);

    logic [PHY_DW-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  addr_q;
    logic [PHY_DW-1:0] wdat_q;
    logic              fresh_q;
    logic [CNT_W-1:0]  cnt;

    // Delay the ack and apply the requested operation when it fires
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            addr_q    <= '0;
            wdat_q    <= '0;
            fresh_q   <= 1'b0;
            cnt       <= '0;
            phy_ack   <= 1'b0;
            phy_rdata <= '0;
        end else if (|phy_req && !phy_ack) begin
            if (cnt == CNT_LAST) begin
                cnt     <= '0;
                phy_ack <= 1'b1;
                if (phy_req[OP_CADDR]) begin
                    addr_q  <= phy_bus[IDX_W-1:0];
                    fresh_q <= 1'b1;
                end
                if (phy_req[OP_CDATA])
                    wdat_q <= phy_bus;
                if (phy_req[OP_WRITE])
                    mem[addr_q] <= wdat_q;
                if (phy_req[OP_READ]) begin
                    if (fresh_q)
                        fresh_q <= 1'b0;
                    else
                        phy_rdata <= mem[addr_q];
                end
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt     <= '0;
            phy_ack <= 1'b0;
        end
    end
endmodule

// File: rtl/phy_creg_bridge.sv
// Top of the PHY control-register bridge: host register file,
// handshake sequencer and the stand-in PHY register array.
// Assumes a host that polls trigger bits before the next step.
module phy_creg_bridge
    import phy_creg_pkg::*;
#(
    parameter int HOST_AW     = 6,
    parameter int PHY_DW      = 16,
    parameter int MODEL_DEPTH = 16,
    parameter int ACK_DELAY   = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [31:0]        host_wdata,
    output logic [31:0]        host_rdata
);
    logic               busy;
    op_e                cur_op;
    op_e                launch_op;
    logic               launch;
    logic [PHY_DW-1:0]  din_lo;
    logic [PHY_DW-1:0]  dout;
    logic [NUM_OPS-1:0] phy_req;
    logic [PHY_DW-1:0]  phy_bus;
    logic               phy_ack;
    logic [PHY_DW-1:0]  phy_rdata;

    phy_creg_regs #(.HOST_AW(HOST_AW), .PHY_DW(PHY_DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
        .cur_op(cur_op), .dout(dout), .din_lo(din_lo), .launch(launch),
        .launch_op(launch_op)
    );

    phy_creg_seq #(.PHY_DW(PHY_DW)) u_seq (
        .clk(clk), .rst_n(rst_n), .launch(launch), .launch_op(launch_op),
        .din_lo(din_lo), .busy(busy), .cur_op(cur_op), .phy_req(phy_req),
        .phy_bus(phy_bus), .phy_ack(phy_ack), .phy_rdata(phy_rdata),
        .dout(dout)
    );

    phy_creg_model #(.PHY_DW(PHY_DW), .DEPTH(MODEL_DEPTH), .ACK_DELAY(ACK_DELAY)) u_phy (
        .clk(clk), .rst_n(rst_n), .phy_req(phy_req), .phy_bus(phy_bus),
        .phy_ack(phy_ack), .phy_rdata(phy_rdata)
    );
endmodule

// File: rtl/phy_creg_bridge_chk.sv
// Assertion checker for the bridge, attached through bind.
// Observes the PHY handshake, the busy flag and data-out.
module phy_creg_bridge_chk
    import phy_creg_pkg::*;
#(
    parameter int PHY_DW    = 16,
    parameter int ACK_DELAY = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OPS-1:0] phy_req,
    input logic               phy_ack,
    input logic               busy,
    input logic [PHY_DW-1:0]  dout
);
    int unsigned busy_len;

    // Count consecutive busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_len <= 0;
        else if (busy) busy_len <= busy_len + 1;
        else           busy_len <= 0;
    end

    a_r3_single_request: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(phy_req));
    a_r3_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (|phy_req && !phy_ack) |=> $stable(phy_req));
    a_r3_drop_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ack |=> (phy_req == '0));
    a_r3_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        phy_ack |-> (|phy_req));
    a_r3_bounded_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_len <= ACK_DELAY + 1);
    a_r6_dout_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !(phy_ack && phy_req[OP_READ]) |=> $stable(dout));
endmodule

bind phy_creg_bridge phy_creg_bridge_chk #(.PHY_DW(PHY_DW), .ACK_DELAY(ACK_DELAY)) u_chk (
    .clk(clk), .rst_n(rst_n), .phy_req(phy_req), .phy_ack(phy_ack),
    .busy(busy), .dout(dout)
);

// File: tb/phy_creg_bridge_test.sv
`timescale 1ns/1ps
module phy_creg_bridge_test;
    localparam int ACK_D = 3;
    localparam logic [5:0] DIN = 6'h0C, DOUT = 6'h10, CADDR = 6'h14,
                           CDATA = 6'h18, RDS = 6'h1C, WRS = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [5:0]  host_addr = DOUT;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    phy_creg_bridge uut (.clk(clk), .rst_n(rst_n), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata));

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Behavioural reference model
    logic [31:0] m_din;
    logic [15:0] m_dout, m_last, m_pd, m_snap;
    logic [15:0] m_mem [16];
    logic [3:0]  m_pa;
    logic        m_fresh;
    int          m_cnt, m_op;

    always @(posedge clk) begin
        bit was_busy;
        if (!rst_n) begin
            m_din = '0; m_dout = '0; m_last = '0; m_pd = '0; m_snap = '0;
            m_pa = '0; m_fresh = 1'b0; m_cnt = 0; m_op = 0;
            for (int i = 0; i < 16; i++) m_mem[i] = '0;
        end else begin
            was_busy = (m_cnt > 0);
            if (m_cnt > 0) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    case (m_op)
                        0: begin m_pa = m_snap[3:0]; m_fresh = 1'b1; end
                        1: m_pd = m_snap;
                        2: begin
                            if (m_fresh) m_fresh = 1'b0;
                            else m_last = m_mem[m_pa];
                            m_dout = m_last;
                        end
                        default: m_mem[m_pa] = m_pd;
                    endcase
                end
            end
            if (host_wr) begin
                if (host_addr == DIN) m_din = host_wdata;
                else if (host_wdata[0] && !was_busy &&
                         (host_addr == CADDR || host_addr == CDATA ||
                          host_addr == RDS || host_addr == WRS)) begin
                    m_op   = (host_addr == CADDR) ? 0 : (host_addr == CDATA) ? 1 :
                             (host_addr == RDS) ? 2 : 3;
                    m_snap = m_din[15:0];
                    m_cnt  = ACK_D + 1;
                end
            end
        end
    end

    function automatic logic [31:0] exp_rd(logic [5:0] a);
        logic b;
        b = (m_cnt > 0);
        case (a)
            DIN:   return m_din;
            DOUT:  return {b, 15'd0, m_dout};
            CADDR: return {31'd0, b && m_op == 0};
            CDATA: return {31'd0, b && m_op == 1};
            RDS:   return {31'd0, b && m_op == 2};
            WRS:   return {31'd0, b && m_op == 3};
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(logic [5:0] a);
        case (a)
            DIN:  return "R2";
            DOUT: return "R6";
            CADDR, CDATA, RDS, WRS: return "R3";
            default: return "R9";
        endcase
    endfunction

    // Compare the addressed register against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) chk(tag_of(host_addr), host_rdata, exp_rd(host_addr));
    end

    task automatic wr(logic [5:0] a, logic [31:0] d);
        @(posedge clk); #1 host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1 host_wr = 1'b0; host_addr = DOUT;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        @(negedge clk);
        while (host_rdata[31]) begin n++; @(negedge clk); end
    endtask

    task automatic rd(logic [5:0] a, output logic [31:0] d);
        @(posedge clk); #1 host_addr = a;
        @(negedge clk); d = host_rdata;
    endtask

    task automatic step(logic [5:0] a);
        int n;
        wr(a, 32'h1);
        wait_idle(n);
    endtask

    task automatic phy_write(logic [15:0] a, logic [15:0] d);
        wr(DIN, {16'd0, a}); step(CADDR);
        wr(DIN, {16'd0, d}); step(CDATA);
        step(WRS);
    endtask

    task automatic phy_read(output logic [15:0] d);
        logic [31:0] v;
        step(RDS);
        rd(DOUT, v);
        d = v[15:0];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R3 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [15:0] r;
        int n;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state of every register
        rd(DIN, v);   chk("R1", v, 32'h0);
        rd(DOUT, v);  chk("R1", v, 32'h0);
        rd(CADDR, v); chk("R1", v, 32'h0);
        rd(CDATA, v); chk("R1", v, 32'h0);
        rd(RDS, v);   chk("R1", v, 32'h0);
        rd(WRS, v);   chk("R1", v, 32'h0);

        // R2: full-width data-in readback
        wr(DIN, 32'hFFFF_ABCD);
        rd(DIN, v); chk("R2", v, 32'hFFFF_ABCD);

        // R3: trigger lasts ACK_D+1 cycles, then clears
        wr(DIN, 32'hFFFF_0003);
        wr(CADDR, 32'h1);
        wait_idle(n);
        chk("R3", n, ACK_D + 1);
        rd(CADDR, v); chk("R3", v, 32'h0);

        // R5: three-step writes to two entries
        wr(DIN, 32'h1234); step(CDATA); step(WRS);
        phy_write(16'h0007, 16'h5678);

        // R7: stale first read, fresh second read
        wr(DIN, 32'h3); step(CADDR);
        phy_read(r); chk("R7", {16'd0, r}, 32'h0);
        phy_read(r); chk("R5", {16'd0, r}, 32'h1234);
        wr(DIN, 32'h7); step(CADDR);
        phy_read(r); chk("R7", {16'd0, r}, 32'h1234);
        phy_read(r); chk("R5", {16'd0, r}, 32'h5678);

        // R6: data-out holds across non-read operations
        wr(DIN, 32'hAAAA);
        wr(DIN, 32'h3); step(CADDR);
        rd(DOUT, v); chk("R6", v, 32'h5678);
        phy_read(r); chk("R7", {16'd0, r}, 32'h5678);
        phy_read(r); chk("R6", {16'd0, r}, 32'h1234);

        // R4: bit 0 clear is ignored
        wr(WRS, 32'h2);
        rd(WRS, v);  chk("R4", v, 32'h0);
        rd(DOUT, v); chk("R4", v, 32'h1234);
        // R4: trigger while busy is ignored
        wr(DIN, 32'h7); step(CADDR);
        wr(DIN, 32'h9999);
        wr(CDATA, 32'h1);
        wr(WRS, 32'h1);
        wait_idle(n);
        rd(WRS, v); chk("R4", v, 32'h0);
        phy_read(r); chk("R7", {16'd0, r}, 32'h1234);
        phy_read(r); chk("R4", {16'd0, r}, 32'h5678);

        // R8: data-in change after launch does not affect the operation
        wr(DIN, 32'h3);
        wr(CADDR, 32'h1);
        wr(DIN, 32'h9);
        wait_idle(n);
        phy_read(r);
        phy_read(r); chk("R8", {16'd0, r}, 32'h1234);

        // R9: writes to data-out or unmapped offsets are ignored
        wr(DOUT, 32'hFFFF_FFFF);
        rd(DOUT, v); chk("R9", v, 32'h1234);
        wr(6'h24, 32'h1);
        rd(DOUT, v); chk("R9", v, 32'h1234);
        rd(6'h00, v); chk("R9", v, 32'h0);

        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule